// File: doc/BRIEF.md
# Subframe Parity Guard with Sample Concealment

This block sits behind a line decoder for a one-way serial digital audio link. Each cycle it may receive one 32-bit subframe that has already been recovered from the line, together with a channel index. It recomputes the even parity that the transmitter placed in the top bit and uses the result to judge whether the subframe arrived intact. The 24-bit audio field then goes to a downstream converter interface exactly one clock later.

A single parity bit can only detect an error. It cannot locate the flipped bit, and the receiver has no way to ask for the subframe again. A damaged sample is therefore handled on the spot, according to a concealment mode chosen per subframe. The mode can mute the sample, repeat the last intact sample of the same channel, or forward the damaged value as received. Every damaged sample is flagged on the output and counted in a saturating counter that can be cleared.

Top module: `spdif_parity_guard`

## Requirements
- R1: For an intact subframe, the output sample equals input bits [27:4]. Bits [3:0] are the sync field, bits [31:28] are the flag/status field, and bit 31 is the parity bit.
- R2: A subframe is damaged exactly when the XOR of input bits [31:4] is 1. The sync field bits [3:0] never affect the decision.
- R3: With a damaged subframe and mode 0, the output sample is zero. Mode 3 behaves like mode 0.
- R4: With a damaged subframe and mode 1, the output sample is the most recent intact sample of the same channel, or zero if that channel has had no intact sample since reset.
- R5: With a damaged subframe and mode 2, the output sample is input bits [27:4] unchanged.
- R6: An output valid pulse with the input's channel index follows every input valid after exactly one clock, and no output valid appears without one. The latency is the same for intact and damaged subframes.
- R7: The error flag is high exactly in the output cycles that carry a damaged sample.
- R8: The error counter rises by one for each damaged subframe and saturates at 65535.
- R9: The clear input sets the counter to zero on the next clock, and it takes priority over an increment in the same cycle.
- R10: After reset, output valid, error flag, sample and counter are all zero.
- R11: A subframe presented without input valid changes neither the outputs' valid/error state, nor the counter, nor the held samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sf_valid_i | input | 1 | Subframe present this cycle |
| sf_chan_i | input | 1 | Channel index of the subframe |
| sf_word_i | input | 32 | Decoded subframe |
| mode_i | input | 2 | Concealment mode: 0 mute, 1 hold, 2 pass, 3 mute |
| err_clr_i | input | 1 | Clear the error counter |
| smp_valid_o | output | 1 | Output sample valid |
| smp_chan_o | output | 1 | Channel index of the output sample |
| smp_data_o | output | 24 | Output audio sample |
| smp_err_o | output | 1 | Output sample came from a damaged subframe |
| err_cnt_o | output | 16 | Saturating count of damaged subframes |

## Verification
A corrupted held sample stays hidden until the next damaged subframe on that channel arrives in mode 1. At that point it appears in the output one clock later, so the bench interleaves channels and modes at random to expose such faults soon after they occur. A wrong parity decision shows up in the same output cycle as a mismatch between the flag and the data. Counter faults show up on every damaged subframe. Saturation and clear priority only show up at the limit, so they are driven directly.

// File: rtl/spdif_guard_pkg.sv
package spdif_guard_pkg;
  typedef enum logic [1:0] {
    CONCEAL_ZERO = 2'd0,
    CONCEAL_HOLD = 2'd1,
    CONCEAL_PASS = 2'd2,
    CONCEAL_MUTE = 2'd3
  } conceal_e;
endpackage

// File: rtl/sfg_parity.sv
module sfg_parity #(
  parameter int unsigned COV_W = 28
) (
  input  logic [COV_W-1:0] covered_i,
  output logic             bad_o
);
  // even parity: intact when XOR of covered bits is zero
  assign bad_o = ^covered_i;
endmodule

// File: rtl/sfg_hold_bank.sv
module sfg_hold_bank #(
  parameter int unsigned N_CH  = 2,
  parameter int unsigned AUD_W = 24,
  localparam int unsigned CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [AUD_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]  rd_ch_i,
  output logic [AUD_W-1:0] rd_data_o
);
  logic [AUD_W-1:0] hold_q [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q[c] <= '0;
      else if (wr_en_i && (wr_ch_i == CH_W'(c))) hold_q[c] <= wr_data_i;
    end
  end

  assign rd_data_o = hold_q[rd_ch_i];
endmodule

// File: rtl/sfg_err_cnt.sv
module sfg_err_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;  // clear beats increment
    else if (inc_i && (cnt_q != '1)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/spdif_parity_guard.sv
module spdif_parity_guard
  import spdif_guard_pkg::*;
#(
  parameter int unsigned SF_W    = 32,
  parameter int unsigned AUD_LSB = 4,
  parameter int unsigned AUD_W   = 24,
  parameter int unsigned N_CH    = 2,
  parameter int unsigned CNT_W   = 16,
  localparam int unsigned CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned COV_W  = SF_W - AUD_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sf_valid_i,
  input  logic [CH_W-1:0]  sf_chan_i,
  input  logic [SF_W-1:0]  sf_word_i,
  input  logic [1:0]       mode_i,
  input  logic             err_clr_i,
  output logic             smp_valid_o,
  output logic [CH_W-1:0]  smp_chan_o,
  output logic [AUD_W-1:0] smp_data_o,
  output logic             smp_err_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic [AUD_W-1:0] aud;
  logic [AUD_W-1:0] held;
  logic [AUD_W-1:0] sel;
  logic             bad;
  logic             unused_sync;
  conceal_e         mode;

  assign aud         = sf_word_i[AUD_LSB +: AUD_W];
  assign unused_sync = ^sf_word_i[AUD_LSB-1:0];
  assign mode        = conceal_e'(mode_i);

  sfg_parity #(.COV_W(COV_W)) parity_i (
    .covered_i (sf_word_i[SF_W-1:AUD_LSB]),
    .bad_o     (bad)
  );

  sfg_hold_bank #(.N_CH(N_CH), .AUD_W(AUD_W)) hold_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (sf_valid_i && !bad),
    .wr_ch_i   (sf_chan_i),
    .wr_data_i (aud),
    .rd_ch_i   (sf_chan_i),
    .rd_data_o (held)
  );

  sfg_err_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sf_valid_i && bad),
    .clr_i  (err_clr_i),
    .cnt_o  (err_cnt_o)
  );

  always_comb begin
    sel = aud;
    if (bad) begin
      unique case (mode)
        CONCEAL_HOLD: sel = held;
        CONCEAL_PASS: sel = aud;
        default:      sel = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_valid_o <= 1'b0;
      smp_chan_o  <= '0;
      smp_data_o  <= '0;
      smp_err_o   <= 1'b0;
    end else begin
      smp_valid_o <= sf_valid_i;
      smp_err_o   <= sf_valid_i && bad;
      if (sf_valid_i) begin
        smp_chan_o <= sf_chan_i;
        smp_data_o <= sel;
      end
    end
  end
endmodule

// File: rtl/spdif_parity_guard_chk.sv
module spdif_parity_guard_chk #(
  parameter int unsigned SF_W  = 32,
  parameter int unsigned AUD_W = 24,
  parameter int unsigned CH_W  = 1,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sf_valid_i,
  input logic [CH_W-1:0]  sf_chan_i,
  input logic [SF_W-1:0]  sf_word_i,
  input logic [1:0]       mode_i,
  input logic             err_clr_i,
  input logic             smp_valid_o,
  input logic [CH_W-1:0]  smp_chan_o,
  input logic [AUD_W-1:0] smp_data_o,
  input logic             smp_err_o,
  input logic [CNT_W-1:0] err_cnt_o
);
  p_valid_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sf_valid_i |=> (smp_valid_o && smp_chan_o == $past(sf_chan_i)));

  p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sf_valid_i |=> !smp_valid_o);

  p_err_qual_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_err_o |-> smp_valid_o);

  p_mute_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_i && (^sf_word_i[SF_W-1:4]) && (mode_i == 2'd0 || mode_i == 2'd3))
      |=> (smp_err_o && smp_data_o == '0));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_i && (^sf_word_i[SF_W-1:4]) && mode_i == 2'd2)
      |=> (smp_err_o && smp_data_o == $past(sf_word_i[4 +: AUD_W])));

  p_good_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sf_valid_i && !(^sf_word_i[SF_W-1:4]))
      |=> (!smp_err_o && smp_data_o == $past(sf_word_i[4 +: AUD_W])));

  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_i |=> err_cnt_o == '0);

  p_sat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_cnt_o == '1 && !err_clr_i) |=> err_cnt_o == '1);

  p_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_clr_i && !(sf_valid_i && (^sf_word_i[SF_W-1:4]))) |=> $stable(err_cnt_o));
endmodule

bind spdif_parity_guard spdif_parity_guard_chk #(
  .SF_W(SF_W), .AUD_W(AUD_W), .CH_W(CH_W), .CNT_W(CNT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .sf_valid_i(sf_valid_i), .sf_chan_i(sf_chan_i),
  .sf_word_i(sf_word_i), .mode_i(mode_i), .err_clr_i(err_clr_i),
  .smp_valid_o(smp_valid_o), .smp_chan_o(smp_chan_o), .smp_data_o(smp_data_o),
  .smp_err_o(smp_err_o), .err_cnt_o(err_cnt_o)
);

// File: tb/spdif_parity_guard_tb_top.sv
`timescale 1ns/1ps
module spdif_parity_guard_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sf_valid_i = 1'b0;
  logic        sf_chan_i = 1'b0;
  logic [31:0] sf_word_i = '0;
  logic [1:0]  mode_i = '0;
  logic        err_clr_i = 1'b0;
  logic        smp_valid_o;
  logic        smp_chan_o;
  logic [23:0] smp_data_o;
  logic        smp_err_o;
  logic [15:0] err_cnt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] m_hold [2];
  logic [15:0] m_cnt;

  always #2 clk_i = ~clk_i;

  spdif_parity_guard dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [23:0] aud, input logic [2:0] flg,
                                     input logic [3:0] sync, input bit bad);
    logic p;
    p = (^{flg, aud}) ^ bad;
    return {p, flg, aud, sync};
  endfunction

  function automatic logic [23:0] exp_data(input logic [31:0] w, input logic ch,
                                           input logic [1:0] md);
    if (!(^w[31:4])) return w[27:4];
    case (md)
      2'd1:    return m_hold[ch];
      2'd2:    return w[27:4];
      default: return 24'd0;
    endcase
  endfunction

  task automatic send(input logic [31:0] w, input logic ch, input logic [1:0] md,
                      input logic clr, input bit do_chk);
    logic [23:0] ed;
    logic        eb;
    ed = exp_data(w, ch, md);
    eb = ^w[31:4];
    sf_word_i = w; sf_chan_i = ch; mode_i = md; err_clr_i = clr; sf_valid_i = 1'b1;
    if (!eb) m_hold[ch] = w[27:4];
    if (clr) m_cnt = '0;
    else if (eb && m_cnt != 16'hFFFF) m_cnt = m_cnt + 1'b1;
    @(negedge clk_i);
    if (do_chk) begin
      check("R6 valid", {31'd0, smp_valid_o}, 32'd1);
      check("R6 chan", {31'd0, smp_chan_o}, {31'd0, ch});
      check(eb ? (md == 2'd1 ? "R4 data" : (md == 2'd2 ? "R5 data" : "R3 data")) : "R1 data",
            {8'd0, smp_data_o}, {8'd0, ed});
      check("R2/R7 err flag", {31'd0, smp_err_o}, {31'd0, eb});
      check("R8 count", {16'd0, err_cnt_o}, {16'd0, m_cnt});
    end
  endtask

  task automatic idle(input logic [31:0] w);
    sf_valid_i = 1'b0; err_clr_i = 1'b0; sf_word_i = w;
    @(negedge clk_i);
    check("R11 no valid", {31'd0, smp_valid_o}, 32'd0);
    check("R11 no err", {31'd0, smp_err_o}, 32'd0);
    check("R11 count kept", {16'd0, err_cnt_o}, {16'd0, m_cnt});
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_hold[0] = '0; m_hold[1] = '0; m_cnt = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 valid", {31'd0, smp_valid_o}, 32'd0);
    check("R10 err", {31'd0, smp_err_o}, 32'd0);
    check("R10 data", {8'd0, smp_data_o}, 32'd0);
    check("R10 count", {16'd0, err_cnt_o}, 32'd0);

    // R4: hold before any intact sample gives zero
    send(mk(24'hABCDEF, 3'd5, 4'h9, 1'b1), 1'b1, 2'd1, 1'b0, 1'b1);
    // R1/R2: sync field ignored by parity
    send(mk(24'h123456, 3'd0, 4'hF, 1'b0), 1'b0, 2'd0, 1'b0, 1'b1);
    send(mk(24'h123456, 3'd0, 4'h1, 1'b0), 1'b0, 2'd0, 1'b0, 1'b1);
    // R3: mode 3 mutes
    send(mk(24'h7FFFFF, 3'd7, 4'h0, 1'b1), 1'b0, 2'd3, 1'b0, 1'b1);
    // R11: invalid subframes leave hold untouched
    idle(mk(24'h555555, 3'd1, 4'h2, 1'b0));
    idle(mk(24'h0F0F0F, 3'd2, 4'h3, 1'b0));
    send(mk(24'h800000, 3'd0, 4'h0, 1'b1), 1'b0, 2'd1, 1'b0, 1'b1);
    send(mk(24'h800000, 3'd0, 4'h0, 1'b1), 1'b1, 2'd1, 1'b0, 1'b1);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'd0) idle($urandom);
      else send(mk(24'($urandom), 3'($urandom), 4'($urandom), r[0] & r[1]),
                r[2], 2'($urandom), (r[15:10] == 6'd0), 1'b1);
    end

    // R9: clear beats a simultaneous increment
    send(mk(24'h000001, 3'd0, 4'h0, 1'b1), 1'b0, 2'd2, 1'b1, 1'b1);
    check("R9 cleared", {16'd0, err_cnt_o}, 32'd0);

    // R8: saturation
    for (int i = 0; i < 65540; i++)
      send(mk(24'(i), 3'd0, 4'h0, 1'b1), 1'(i), 2'd0, 1'b0, 1'b0);
    @(negedge clk_i);
    check("R8 saturated", {16'd0, err_cnt_o}, 32'h0000FFFF);
    send(mk(24'h000002, 3'd1, 4'h0, 1'b1), 1'b1, 2'd2, 1'b0, 1'b1);
    check("R8 stays saturated", {16'd0, err_cnt_o}, 32'h0000FFFF);
    send(mk(24'h000003, 3'd1, 4'h0, 1'b0), 1'b1, 2'd0, 1'b1, 1'b1);
    check("R9 clear from max", {16'd0, err_cnt_o}, 32'd0);
    idle(32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule